// File: doc/BRIEF.md
# Serial Peripheral Master with Select Management

This block is a byte-wide serial peripheral interface controller that drives the serial clock as bus master. Software programs a control register with an enable bit, a master bit, clock polarity, clock phase and a three-bit rate field. Writing a byte into the data register starts one full-duplex exchange of eight bits. The byte goes out on the data output with the most significant bit first, while the same number of bits is captured from the data input. A status view reports busy, done, write-collision and mode-fault conditions.

The block keeps an internal "clear to master" select. A management bit chooses its source: either a software-held bit or the active-low select pin. Whenever that internal select is low while the master bit is set, hardware drops both the master and enable bits and records a mode fault. Any exchange in flight is aborted and the serial clock returns to its idle level.

Top module: `spi_ss_master`

## Requirements
- R1: After reset every register field reads 0 (control at address 0, select/status at address 1), the serial clock is low and the data output is low.
- R2: While no exchange is in progress, the serial clock sits at the polarity bit (control bit 2): high when it is 1, low when it is 0.
- R3: During an exchange, the serial clock toggles every H system cycles, where H = 2 << rate for rate 0..5 and H = 128 for rate 6 and 7. The rate is control bits 6:4, so the full period is 4, 8, 16, 32, 64, 128 or 256 cycles.
- R4: A write to the data register (address 2) starts an exchange when enable (control bit 0) and master (control bit 1) are set and the internal select is high. After completion, a data register read returns the eight bits received, first-received bit in bit 7.
- R5: Transmission goes most significant bit first. With phase 0 (control bit 3 clear), the first bit is on the output before the first clock edge, and both sides sample on leading edges. With phase 1, the output changes on leading edges and both sides sample on trailing edges.
- R6: When the management bit (address 1 bit 1) is 1, the internal select equals the software bit (address 1 bit 0) and the pin has no effect. When it is 0, the internal select follows the pin.
- R7: If the internal select is low while the master bit is set, hardware clears master and enable, sets the mode-fault flag (status bit 5) and aborts any exchange. The other control fields keep their values.
- R8: The busy flag (status bit 4) is 1 during an exchange. The done flag (status bit 7) is set when the exchange ends. A status read followed by a data register access clears done.
- R9: A data register write during an exchange is ignored and sets the collision flag (status bit 6). The byte being shifted is unaffected. The collision flag clears with the same sequence as done.
- R10: The mode-fault flag clears only when a status read that sees it set is followed by a control register write. A control write without that prior read leaves it set.
- R11: A data register write while enable or master is clear starts nothing: busy stays 0 and the clock stays idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | 2 | Register select: 0 control, 1 select/status, 2 data |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (needed for flag-clearing sequences) |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for the addressed register |
| ss_n_pin | input | 1 | External select pin, low means another master claims the bus |
| miso | input | 1 | Serial data input |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data output |

## Verification
The assertions assume the select pin and the serial input are already synchronous to the system clock. They also assume that a read strobe and a write strobe are never raised in the same cycle. The bench changes every input only on the falling clock edge, and it issues one register access at a time. The serial input is driven by a bench slave model that changes it only on the clock edge opposite the sampling edge. The select pin is pulled low only at moments chosen to provoke a mode fault.

// File: rtl/spi_ss_pkg.sv
package spi_ss_pkg;
  localparam int unsigned BYTE_W      = 8;
  localparam int unsigned RATE_W      = 3;
  localparam int unsigned DIV_LO_LOG2 = 2;
  localparam int unsigned DIV_HI_LOG2 = 8;
  localparam int unsigned CNT_W       = DIV_HI_LOG2;

  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_SEL  = 2'd1;
  localparam logic [1:0] ADDR_DATA = 2'd2;

  // half serial-clock period in system cycles for a rate code
  function automatic logic [CNT_W-1:0] half_period(input logic [RATE_W-1:0] rate);
    int unsigned sh;
    sh = int'(rate) + DIV_LO_LOG2 - 1;
    if (sh > DIV_HI_LOG2 - 1) sh = DIV_HI_LOG2 - 1;
    return CNT_W'(1) << sh;
  endfunction
endpackage

// File: rtl/spi_ss_div.sv
module spi_ss_div #(
  parameter int unsigned CNT_W = spi_ss_pkg::CNT_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             restart,
  input  logic [CNT_W-1:0] half,
  output logic             tick
);
  logic [CNT_W-1:0] cnt;

  assign tick = run && !restart && (cnt == half - 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     cnt <= '0;
    else if (restart || !run || tick) cnt <= '0;
    else                            cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/spi_ss_engine.sv
module spi_ss_engine #(
  parameter int unsigned BYTE_W = spi_ss_pkg::BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [BYTE_W-1:0] load,
  input  logic              abort,
  input  logic              tick,
  input  logic              cpha,
  input  logic              miso,
  output logic              busy,
  output logic              phase,
  output logic              mosi,
  output logic [BYTE_W-1:0] shreg,
  output logic              xfer_end
);
  localparam int unsigned LAST   = 2 * BYTE_W;
  localparam int unsigned STEP_W = $clog2(LAST + 1);

  logic [STEP_W-1:0] step;
  logic              samp;
  logic              at_last, sample_now, shift_now;

  assign at_last    = (step == STEP_W'(LAST));
  assign sample_now = tick && !at_last && (step[0] == cpha);
  assign shift_now  = tick && (step != '0) && (step[0] != cpha);
  assign xfer_end   = busy && tick && at_last;
  assign mosi       = shreg[BYTE_W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0; phase <= 1'b0; step <= '0; samp <= 1'b0; shreg <= '0;
    end else if (abort) begin
      busy <= 1'b0; phase <= 1'b0; step <= '0;
    end else if (start) begin
      busy <= 1'b1; phase <= 1'b0; step <= '0; shreg <= load;
    end else if (tick) begin
      step <= step + 1'b1;
      if (!at_last)  phase <= ~phase;
      if (sample_now) samp <= miso;
      if (shift_now)  shreg <= {shreg[BYTE_W-2:0], samp};
      if (at_last) begin
        busy <= 1'b0;
        step <= '0;
      end
    end
  end
endmodule

// File: rtl/spi_ss_master.sv
module spi_ss_master
  import spi_ss_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] reg_addr,
  input  logic       reg_wr,
  input  logic       reg_rd,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  input  logic       ss_n_pin,
  input  logic       miso,
  output logic       sck,
  output logic       mosi
);
  logic              ctl_en, ctl_mstr, ctl_cpol, ctl_cpha;
  logic [RATE_W-1:0] ctl_rate;
  logic              ssi, ssm, modf, wcol, done, done_arm, modf_arm;
  logic              busy, phase, tick, xfer_end;
  logic [BYTE_W-1:0] shreg;
  logic [CNT_W-1:0]  half;

  // named internal events
  logic ss_int, fault_evt, wr_ctrl, wr_sel, wr_data, rd_sel, acc_data;
  logic start_xfer, wcol_evt, abort;

  assign ss_int     = ssm ? ssi : ss_n_pin;
  assign fault_evt  = !ss_int && ctl_mstr;
  assign wr_ctrl    = reg_wr && (reg_addr == ADDR_CTRL);
  assign wr_sel     = reg_wr && (reg_addr == ADDR_SEL);
  assign wr_data    = reg_wr && (reg_addr == ADDR_DATA);
  assign rd_sel     = reg_rd && (reg_addr == ADDR_SEL);
  assign acc_data   = (reg_wr || reg_rd) && (reg_addr == ADDR_DATA);
  assign start_xfer = wr_data && ctl_en && ctl_mstr && ss_int && !busy;
  assign wcol_evt   = wr_data && busy;
  assign abort      = fault_evt || !ctl_en || !ctl_mstr;
  assign half       = half_period(ctl_rate);

  spi_ss_div #(.CNT_W(CNT_W)) u_div (
    .clk(clk), .rst_n(rst_n), .run(busy), .restart(start_xfer),
    .half(half), .tick(tick)
  );

  spi_ss_engine #(.BYTE_W(BYTE_W)) u_eng (
    .clk(clk), .rst_n(rst_n), .start(start_xfer), .load(reg_wdata[BYTE_W-1:0]),
    .abort(abort), .tick(tick), .cpha(ctl_cpha), .miso(miso),
    .busy(busy), .phase(phase), .mosi(mosi), .shreg(shreg), .xfer_end(xfer_end)
  );

  assign sck = ctl_cpol ^ phase;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_en <= 1'b0; ctl_mstr <= 1'b0; ctl_cpol <= 1'b0; ctl_cpha <= 1'b0;
      ctl_rate <= '0; ssi <= 1'b0; ssm <= 1'b0;
    end else begin
      if (wr_ctrl) begin
        ctl_en   <= reg_wdata[0];
        ctl_mstr <= reg_wdata[1];
        ctl_cpol <= reg_wdata[2];
        ctl_cpha <= reg_wdata[3];
        ctl_rate <= reg_wdata[4 +: RATE_W];
      end
      if (fault_evt) begin
        ctl_en   <= 1'b0;
        ctl_mstr <= 1'b0;
      end
      if (wr_sel) begin
        ssi <= reg_wdata[0];
        ssm <= reg_wdata[1];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      modf <= 1'b0; modf_arm <= 1'b0; done <= 1'b0; wcol <= 1'b0; done_arm <= 1'b0;
    end else begin
      if (fault_evt)                 modf <= 1'b1;
      else if (wr_ctrl && modf_arm)  modf <= 1'b0;
      if (wr_ctrl)                   modf_arm <= 1'b0;
      else if (rd_sel && modf)       modf_arm <= 1'b1;

      if (xfer_end)                  done <= 1'b1;
      else if (acc_data && done_arm) done <= 1'b0;
      if (wcol_evt)                  wcol <= 1'b1;
      else if (acc_data && done_arm) wcol <= 1'b0;
      if (acc_data)                  done_arm <= 1'b0;
      else if (rd_sel && (done || wcol)) done_arm <= 1'b1;
    end
  end

  always_comb begin
    case (reg_addr)
      ADDR_CTRL: reg_rdata = {1'b0, ctl_rate, ctl_cpha, ctl_cpol, ctl_mstr, ctl_en};
      ADDR_SEL:  reg_rdata = {done, wcol, modf, busy, 2'b00, ssm, ssi};
      ADDR_DATA: reg_rdata = shreg;
      default:   reg_rdata = 8'h00;
    endcase
  end
endmodule

// File: rtl/spi_ss_master_chk.sv
module spi_ss_master_chk (
  input logic clk,
  input logic rst_n,
  input logic busy,
  input logic sck,
  input logic ctl_cpol,
  input logic ctl_en,
  input logic ctl_mstr,
  input logic fault_evt,
  input logic modf,
  input logic wcol,
  input logic done,
  input logic xfer_end,
  input logic start_xfer,
  input logic wr_data
);
  // R2: idle clock level follows polarity
  a_r2_idle_level: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (sck == ctl_cpol));

  // R4: an accepted data write makes the engine busy
  a_r4_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
    start_xfer |=> busy);

  // R7: low internal select drops master/enable, flags fault, stops exchange
  a_r7_fault_drop: assert property (@(posedge clk) disable iff (!rst_n)
    fault_evt |=> (!ctl_en && !ctl_mstr && modf && !busy));

  // R8: completion raises done
  a_r8_done_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_end |=> done);

  // R9: data write during exchange flags collision
  a_r9_collision: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_data && busy) |=> wcol);

  // R11: busy only ever rises after an accepted start
  a_r11_busy_needs_start: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start_xfer));
endmodule

bind spi_ss_master spi_ss_master_chk u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .sck(sck), .ctl_cpol(ctl_cpol),
  .ctl_en(ctl_en), .ctl_mstr(ctl_mstr), .fault_evt(fault_evt), .modf(modf),
  .wcol(wcol), .done(done), .xfer_end(xfer_end), .start_xfer(start_xfer),
  .wr_data(wr_data)
);

// File: tb/spi_ss_master_test.sv
module spi_ss_master_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic       reg_wr = 1'b0, reg_rd = 1'b0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic       ss_n_pin = 1'b1;
  logic       miso = 1'b0;
  logic       sck, mosi;

  int n_chk = 0, n_err = 0;

  spi_ss_master uut (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ss_n_pin(ss_n_pin),
    .miso(miso), .sck(sck), .mosi(mosi)
  );

  always #5 clk = ~clk;

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", what, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); reg_addr = a; reg_rd = 1'b1;
    #1 d = reg_rdata;
    @(negedge clk); reg_rd = 1'b0;
  endtask

  // slave model and scoreboard
  logic [7:0] slv_tx = 8'h00, slv_rx = 8'h00;
  int         slv_k = 0;
  bit         slv_active = 1'b0, m_cpol = 1'b0, m_cpha = 1'b0, lead;
  logic [7:0] exp_q[$];

  always @(sck) begin
    if (slv_active && rst_n) begin
      lead = (sck != m_cpol);
      if (lead == !m_cpha) begin
        slv_rx = {slv_rx[6:0], mosi};
        slv_k++;
        if (slv_k == 8) begin
          if (exp_q.size() == 0) chk(1'b0, "R5 unexpected byte at slave", slv_rx, 0);
          else begin
            logic [7:0] e;
            e = exp_q.pop_front();
            chk(slv_rx == e, "R5 slave received byte", slv_rx, e);
          end
        end
      end else if (slv_k < 8) begin
        miso = slv_tx[7 - slv_k];
      end
    end
  end

  function automatic int exp_half(input logic [2:0] rate);
    int full;
    full = (rate > 3'd6) ? 256 : (4 << rate);
    return full / 2;
  endfunction

  task automatic poll_done(output logic [7:0] st);
    int n = 0;
    rd(2'd1, st);
    while (!st[7] && n < 3000) begin rd(2'd1, st); n++; end
  endtask

  task automatic run_xfer(input logic [7:0] m_tx, input logic [7:0] s_tx,
                          input bit cp, input bit ch, input logic [2:0] rate);
    logic [7:0] st, d;
    logic prev;
    int n;
    wr(2'd0, {1'b0, rate, ch, cp, 2'b11});
    @(negedge clk);
    chk(sck == cp, "R2 idle clock level", sck, cp);
    m_cpol = cp; m_cpha = ch; slv_tx = s_tx; slv_rx = 8'h00; slv_k = 0;
    if (!ch) miso = s_tx[7];
    slv_active = 1'b1;
    exp_q.push_back(m_tx);
    wr(2'd2, m_tx);
    n = 0; prev = sck;
    while (sck == prev && n < 1000) begin @(negedge clk); n++; end
    n = 0; prev = sck;
    while (sck == prev && n < 1000) begin @(negedge clk); n++; end
    chk(n == exp_half(rate), "R3 half period", n, exp_half(rate));
    rd(2'd1, st);
    chk(st[4] == 1'b1, "R8 busy during exchange", st[4], 1);
    poll_done(st);
    chk(st[7] == 1'b1, "R8 done set", st[7], 1);
    chk(st[4] == 1'b0, "R8 busy clear at end", st[4], 0);
    chk(sck == cp, "R2 clock back at idle", sck, cp);
    rd(2'd2, d);
    chk(d == s_tx, "R4 received byte", d, s_tx);
    rd(2'd1, st);
    chk(st[7] == 1'b0, "R8 done cleared by status then data", st[7], 0);
    slv_active = 1'b0;
  endtask

  initial begin
    #(200000 * 10);
    n_chk++; n_err++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    logic [7:0] st, d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    rd(2'd0, d); chk(d == 8'h00, "R1 control after reset", d, 0);
    rd(2'd1, d); chk(d == 8'h00, "R1 status after reset", d, 0);
    chk(sck == 1'b0, "R1 clock after reset", sck, 0);
    chk(mosi == 1'b0, "R1 data out after reset", mosi, 0);

    // R11 no start without master
    wr(2'd0, 8'h01);
    wr(2'd2, 8'h99);
    repeat (4) @(negedge clk);
    rd(2'd1, st); chk(st[4] == 1'b0, "R11 no busy without master", st[4], 0);
    chk(sck == 1'b0, "R11 clock idle", sck, 0);

    // R6 software select
    wr(2'd1, 8'h03);
    wr(2'd0, 8'h03);
    rd(2'd0, d); chk(d == 8'h03, "R6 master held by soft select", d, 8'h03);

    // R4/R5 four modes and rates
    run_xfer(8'hA5, 8'h3C, 1'b0, 1'b0, 3'd0);
    run_xfer(8'h5A, 8'hC3, 1'b0, 1'b1, 3'd1);
    run_xfer(8'hFF, 8'h00, 1'b1, 1'b0, 3'd2);
    run_xfer(8'h01, 8'h80, 1'b1, 1'b1, 3'd0);
    run_xfer(8'h96, 8'h69, 1'b0, 1'b0, 3'd7);

    // R6 pin ignored under soft select
    ss_n_pin = 1'b0;
    repeat (3) @(negedge clk);
    rd(2'd0, d); chk(d[1:0] == 2'b11, "R6 pin ignored", d, 8'h03);
    rd(2'd1, st); chk(st[5] == 1'b0, "R6 no fault from pin", st[5], 0);
    // R6 soft bit low causes fault
    wr(2'd1, 8'h02);
    rd(2'd0, d); chk(d[1:0] == 2'b00, "R6 soft select low drops master", d, 0);
    rd(2'd1, st); chk(st[5] == 1'b1, "R6 fault flagged", st[5], 1);
    ss_n_pin = 1'b1;
    wr(2'd1, 8'h03);
    wr(2'd0, 8'h03);
    rd(2'd1, st); chk(st[5] == 1'b0, "R10 fault cleared", st[5], 0);

    // R9 write collision
    wr(2'd0, 8'h03);
    m_cpol = 1'b0; m_cpha = 1'b0; slv_tx = 8'h1E; slv_rx = 8'h00; slv_k = 0;
    miso = slv_tx[7]; slv_active = 1'b1;
    exp_q.push_back(8'hC5);
    wr(2'd2, 8'hC5);
    repeat (6) @(negedge clk);
    wr(2'd2, 8'h77);
    poll_done(st);
    chk(st[6] == 1'b1, "R9 collision flagged", st[6], 1);
    rd(2'd2, d); chk(d == 8'h1E, "R9 exchange unaffected", d, 8'h1E);
    rd(2'd1, st); chk(st[6] == 1'b0, "R9 collision cleared", st[6], 0);
    slv_active = 1'b0;

    // R7 fault from pin mid-exchange
    wr(2'd1, 8'h00);
    wr(2'd0, 8'h23);
    wr(2'd2, 8'hAA);
    repeat (10) @(negedge clk);
    ss_n_pin = 1'b0;
    repeat (2) @(negedge clk);
    rd(2'd0, d); chk(d == 8'h20, "R7 master and enable dropped, rate kept", d, 8'h20);
    chk(sck == 1'b0, "R7 clock idle after abort", sck, 0);
    ss_n_pin = 1'b1;
    // R10 write without prior status read keeps fault
    wr(2'd0, 8'h20);
    rd(2'd1, st);
    chk(st[5] == 1'b1, "R10 fault kept without status read", st[5], 1);
    chk(st[4] == 1'b0, "R7 exchange aborted", st[4], 0);
    wr(2'd0, 8'h03);
    rd(2'd1, st); chk(st[5] == 1'b0, "R10 fault cleared by sequence", st[5], 0);
    rd(2'd0, d); chk(d == 8'h03, "R10 control rewritten", d, 8'h03);

    chk(exp_q.size() == 0, "R5 all bytes seen by slave", exp_q.size(), 0);
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule